// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

After a reset this block acts as the configuration master of a board. It walks a byte-wide boot device with a fixed run of single-byte reads on a simple request/valid memory port. It assembles the returned bytes into one 32-bit configuration word for the master and one word for each of up to seven slave devices. When the last word is complete it raises a done flag, drops its request line for good, and keeps all eight words steady on a flat output vector. The rest of the chip stays held in reset through the busy output for as long as the fetch runs.

Only one read is in flight at any time. A read that gets no response within a set number of cycles is abandoned. The word it belongs to is then replaced by a default value, a sticky error flag is raised, and the fetch moves on to the next word, so a broken device cannot hang the boot. The block does not decode the fields of the words and does not pass them on to the slaves.

Top module: `cfgword_fetch`

## Requirements
- R1: After reset is released the block issues exactly 32 reads when every read is answered. The first read is at address 0. After done rises, `rd_req` stays low until the next reset.
- R2: Read number n (counting from 0) presents address 8*n on `rd_addr`, so every address is a multiple of 8.
- R3: From each response only `rd_data[63:56]` is kept. The other 56 data bits have no effect on any word.
- R4: Reads 4w to 4w+3 build word w, which appears on `cfg_words[32w+31:32w]`. Word 0 belongs to the master and words 1 to 7 to the slaves.
- R5: Within a word the first byte read lands in bits 31:24, the second in 23:16, the third in 15:8 and the fourth in 7:0.
- R6: `rd_req` stays high with `rd_addr` unchanged until `rd_valid` is seen. The response is taken in the cycle where both are high. `rd_req` is then low for at least one cycle before the next request.
- R7: `done` rises on the clock edge that captures the 32nd byte. `busy` is high from reset until `done` rises. Once `done` is high, `done` and `cfg_words` do not change until the next reset.
- R8: If `rd_valid` has not arrived after `rd_req` has been high for TIMEOUT_CYC cycles, the read is abandoned and `cfg_err` is set and stays set. The whole word being built is loaded with DEFAULT_WORD, its remaining reads are skipped, and fetching resumes with the first read of the next word. When the abandoned read belongs to the last word, `done` rises instead.
- R9: While reset is asserted, `rd_req`, `done` and `cfg_err` are low, `busy` is high and every word reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Read request to the boot device, held until answered |
| rd_addr | output | ADDR_W (16) | Byte address of the current read |
| rd_valid | input | 1 | Response valid for the outstanding read |
| rd_data | input | BUS_W (64) | Response data; only the top byte lane is used |
| busy | output | 1 | High while the fetch is in progress (holds the system in reset) |
| done | output | 1 | High once every word is final |
| cfg_err | output | 1 | Sticky flag: at least one read timed out |
| cfg_words | output | NUM_WORDS*32 (256) | Word w on bits [32w+31:32w]; word 0 is the master's |

## Verification
A response offered while `rd_req` is high is captured on the next rising edge. `rd_req` falls on that same edge, and on the edge after the 32nd capture `done` is already high. The bench therefore samples shortly after each rising edge, and at the sample where `done` first reads high it expects the final `rd_valid` still to be asserted. A withheld response must leave `rd_req` high for exactly TIMEOUT_CYC samples before the request drops. Word values are compared only after `done` and again after a quiet stretch, so they are checked once they are final rather than while they are still being filled.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ASK  = 2'd1,
      PH_GAP  = 2'd2,
      PH_FIN  = 2'd3
   } fetch_phase_e;

endpackage

// File: rtl/cfgw_sequencer.sv
module cfgw_sequencer
   import cfgw_pkg::*;
#(
   parameter int unsigned NUM_WORDS      = 8,
   parameter int unsigned BYTES_PER_WORD = 4,
   parameter int unsigned STRIDE         = 8,
   parameter int unsigned ADDR_W         = 16,
   parameter int unsigned TIMEOUT_CYC    = 256
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          rsp_valid_i,
   output logic                                          req_o,
   output logic [ADDR_W-1:0]                             addr_o,
   output logic                                          cap_o,
   output logic                                          tmo_o,
   output logic                                          fin_o,
   output logic [$clog2(NUM_WORDS*BYTES_PER_WORD)-1:0]   idx_o
);

   localparam int unsigned N_READS = NUM_WORDS * BYTES_PER_WORD;
   localparam int unsigned IDX_W   = $clog2(N_READS);
   localparam int unsigned SUB_W   = $clog2(BYTES_PER_WORD);
   localparam int unsigned WSEL_W  = IDX_W - SUB_W;
   localparam int unsigned STEP_SH = $clog2(STRIDE);
   localparam int unsigned TMR_W   = $clog2(TIMEOUT_CYC + 1);

   initial begin : p_param_check
      assert (TIMEOUT_CYC >= 1)
         else $fatal(1, "TIMEOUT_CYC must be at least 1");
      assert (STRIDE >= 1 && (1 << STEP_SH) == STRIDE)
         else $fatal(1, "STRIDE must be a power of two");
      assert (ADDR_W >= IDX_W + STEP_SH)
         else $fatal(1, "ADDR_W too narrow for the last read address");
   end

   fetch_phase_e        phase;
   logic [IDX_W-1:0]    idx;
   logic [TMR_W-1:0]    tmr;
   logic [WSEL_W-1:0]   wsel;
   logic [IDX_W-1:0]    next_word_idx;
   logic                last_read;
   logic                last_word;
   logic                tmr_expired;

   always_comb begin
      wsel          = idx[IDX_W-1:SUB_W];
      next_word_idx = {WSEL_W'(wsel + 1'b1), {SUB_W{1'b0}}};
      last_read     = (idx == IDX_W'(N_READS - 1));
      last_word     = (wsel == WSEL_W'(NUM_WORDS - 1));
      tmr_expired   = (tmr == TMR_W'(TIMEOUT_CYC - 1));
      req_o         = (phase == PH_ASK);
      cap_o         = req_o && rsp_valid_i;
      tmo_o         = req_o && !rsp_valid_i && tmr_expired;
      fin_o         = (phase == PH_FIN);
      addr_o        = req_o ? (ADDR_W'(idx) << STEP_SH) : '0;
      idx_o         = idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
         tmr   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               phase <= PH_ASK;
               tmr   <= '0;
            end
            PH_ASK: begin
               if (cap_o) begin
                  if (last_read) begin
                     phase <= PH_FIN;
                  end else begin
                     idx   <= idx + 1'b1;
                     phase <= PH_GAP;
                  end
               end else if (tmo_o) begin
                  if (last_word) begin
                     phase <= PH_FIN;
                  end else begin
                     idx   <= next_word_idx;
                     phase <= PH_GAP;
                  end
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            PH_GAP: begin
               phase <= PH_ASK;
               tmr   <= '0;
            end
            PH_FIN: begin
               phase <= PH_FIN;
            end
            default: begin
               phase <= PH_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/cfgw_lane_pick.sv
module cfgw_lane_pick
   import cfgw_pkg::*;
#(
   parameter int unsigned BUS_W       = 64,
   parameter bit          LANE_AT_TOP = 1'b1
) (
   input  logic [BUS_W-1:0]  data_i,
   output logic [BYTE_W-1:0] byte_o
);

   initial begin : p_param_check
      assert (BUS_W >= BYTE_W && (BUS_W % BYTE_W) == 0)
         else $fatal(1, "BUS_W must be a whole number of bytes");
   end

   generate
      if (BUS_W == BYTE_W) begin : g_narrow
         assign byte_o = data_i;
      end else if (LANE_AT_TOP) begin : g_top_lane
         logic unused_low_lanes;
         assign byte_o           = data_i[BUS_W-1 -: BYTE_W];
         assign unused_low_lanes = ^data_i[BUS_W-BYTE_W-1:0];
      end else begin : g_bottom_lane
         logic unused_high_lanes;
         assign byte_o            = data_i[BYTE_W-1:0];
         assign unused_high_lanes = ^data_i[BUS_W-1:BYTE_W];
      end
   endgenerate

endmodule

// File: rtl/cfgw_word_bank.sv
module cfgw_word_bank
   import cfgw_pkg::*;
#(
   parameter int unsigned                          NUM_WORDS      = 8,
   parameter int unsigned                          BYTES_PER_WORD = 4,
   parameter logic [8*BYTES_PER_WORD-1:0]          DEFAULT_WORD   = '0
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          cap_i,
   input  logic                                          tmo_i,
   input  logic [$clog2(NUM_WORDS*BYTES_PER_WORD)-1:0]   idx_i,
   input  logic [BYTE_W-1:0]                             byte_i,
   output logic [NUM_WORDS*8*BYTES_PER_WORD-1:0]         words_o
);

   localparam int unsigned WORD_W = BYTE_W * BYTES_PER_WORD;
   localparam int unsigned IDX_W  = $clog2(NUM_WORDS * BYTES_PER_WORD);
   localparam int unsigned SUB_W  = $clog2(BYTES_PER_WORD);
   localparam int unsigned WSEL_W = IDX_W - SUB_W;

   initial begin : p_param_check
      assert (BYTES_PER_WORD >= 2 && (1 << SUB_W) == BYTES_PER_WORD)
         else $fatal(1, "BYTES_PER_WORD must be a power of two, at least 2");
      assert (NUM_WORDS >= 2 && (1 << WSEL_W) == NUM_WORDS)
         else $fatal(1, "NUM_WORDS must be a power of two, at least 2");
   end

   logic [WSEL_W-1:0] wsel;
   logic [SUB_W-1:0]  sub;

   assign wsel = idx_i[IDX_W-1:SUB_W];
   assign sub  = idx_i[SUB_W-1:0];

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic hit;
         assign hit = (wsel == WSEL_W'(w));

         for (genvar k = 0; k < BYTES_PER_WORD; k++) begin : g_slot
            localparam int unsigned POS = (BYTES_PER_WORD - 1 - k) * BYTE_W;
            logic [BYTE_W-1:0] slot;

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  slot <= '0;
               end else if (hit && tmo_i) begin
                  slot <= DEFAULT_WORD[POS +: BYTE_W];
               end else if (hit && cap_i && (sub == SUB_W'(k))) begin
                  slot <= byte_i;
               end
            end

            assign words_o[w*WORD_W + POS +: BYTE_W] = slot;
         end
      end
   endgenerate

endmodule

// File: rtl/cfgword_fetch.sv
module cfgword_fetch
   import cfgw_pkg::*;
#(
   parameter int unsigned                 ADDR_W         = 16,
   parameter int unsigned                 BUS_W          = 64,
   parameter int unsigned                 NUM_WORDS      = 8,
   parameter int unsigned                 BYTES_PER_WORD = 4,
   parameter int unsigned                 STRIDE         = 8,
   parameter int unsigned                 TIMEOUT_CYC    = 256,
   parameter bit                          LANE_AT_TOP    = 1'b1,
   parameter logic [8*BYTES_PER_WORD-1:0] DEFAULT_WORD   = '0
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   output logic                                   rd_req,
   output logic [ADDR_W-1:0]                      rd_addr,
   input  logic                                   rd_valid,
   input  logic [BUS_W-1:0]                       rd_data,
   output logic                                   busy,
   output logic                                   done,
   output logic                                   cfg_err,
   output logic [NUM_WORDS*8*BYTES_PER_WORD-1:0]  cfg_words
);

   localparam int unsigned IDX_W = $clog2(NUM_WORDS * BYTES_PER_WORD);

   logic              cap_stb;
   logic              tmo_stb;
   logic              fin;
   logic [IDX_W-1:0]  rd_idx;
   logic [BYTE_W-1:0] lane_byte;

   cfgw_sequencer #(
      .NUM_WORDS      (NUM_WORDS),
      .BYTES_PER_WORD (BYTES_PER_WORD),
      .STRIDE         (STRIDE),
      .ADDR_W         (ADDR_W),
      .TIMEOUT_CYC    (TIMEOUT_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .rsp_valid_i (rd_valid),
      .req_o       (rd_req),
      .addr_o      (rd_addr),
      .cap_o       (cap_stb),
      .tmo_o       (tmo_stb),
      .fin_o       (fin),
      .idx_o       (rd_idx)
   );

   cfgw_lane_pick #(
      .BUS_W       (BUS_W),
      .LANE_AT_TOP (LANE_AT_TOP)
   ) u_lane (
      .data_i (rd_data),
      .byte_o (lane_byte)
   );

   cfgw_word_bank #(
      .NUM_WORDS      (NUM_WORDS),
      .BYTES_PER_WORD (BYTES_PER_WORD),
      .DEFAULT_WORD   (DEFAULT_WORD)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap_stb),
      .tmo_i   (tmo_stb),
      .idx_i   (rd_idx),
      .byte_i  (lane_byte),
      .words_o (cfg_words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_err <= 1'b0;
      end else if (tmo_stb) begin
         cfg_err <= 1'b1;
      end
   end

   assign done = fin;
   assign busy = !fin;

endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned WORDS_W = 256,
   parameter int unsigned STRIDE  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd_req,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic               rd_valid,
   input logic               done,
   input logic               cfg_err,
   input logic               tmo_stb,
   input logic [WORDS_W-1:0] cfg_words
);

   // R2: every presented address sits on a stride boundary
   a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> ((rd_addr & ADDR_W'(STRIDE - 1)) == '0));

   // R6: an unanswered, unexpired request is held with the same address
   a_r6_hold_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid && !tmo_stb) |=> (rd_req && $stable(rd_addr)));

   // R6: a gap cycle follows every accepted response
   a_r6_gap_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_valid) |=> !rd_req);

   // R1: the bus is left alone once the fetch has finished
   a_r1_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_req);

   // R7: done and the words are frozen once done is high
   a_r7_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(cfg_words)));

   // R8: an expiry raises the error flag, which then stays set
   a_r8_err_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_stb |=> cfg_err);

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

endmodule

bind cfgword_fetch cfgw_checker #(
   .ADDR_W  (ADDR_W),
   .WORDS_W (NUM_WORDS * 8 * BYTES_PER_WORD),
   .STRIDE  (STRIDE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_addr   (rd_addr),
   .rd_valid  (rd_valid),
   .done      (done),
   .cfg_err   (cfg_err),
   .tmo_stb   (tmo_stb),
   .cfg_words (cfg_words)
);

// File: tb/cfgword_fetch_tb.sv
module cfgword_fetch_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 12;
   localparam int NW         = 8;
   localparam int NR         = 32;
   localparam int WD_LIMIT   = 20000;
   localparam logic [31:0] DEFW = 32'hD15A_B1ED;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rd_req;
   logic [15:0]  rd_addr;
   logic         rd_valid = 1'b0;
   logic [63:0]  rd_data = '0;
   logic         busy, done, cfg_err;
   logic [255:0] cfg_words;

   cfgword_fetch #(
      .TIMEOUT_CYC  (TMO),
      .DEFAULT_WORD (DEFW)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .busy      (busy),
      .done      (done),
      .cfg_err   (cfg_err),
      .cfg_words (cfg_words)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          n_cmp = 0;
   int          n_bad = 0;
   int          cyc   = 0;
   logic [15:0] exp_addr_q[$];
   logic [31:0] exp_words[NW];
   bit          drop[NR];
   logic [7:0]  seed = 8'h00;
   bit          mon_en = 1'b0;

   always @(posedge clk) cyc++;

   function automatic logic [7:0] mem_byte(input int i);
      return 8'(i * 37 + 11) ^ seed;
   endfunction

   task automatic check(input bit ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // boot-device model: latency idx%3, withholds the response for dropped reads
   int wcnt = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_valid = 1'b0;
         wcnt = 0;
      end else if (rd_valid) begin
         rd_valid = 1'b0;
         wcnt = 0;
      end else if (rd_req) begin
         int idx;
         idx = int'(rd_addr >> 3);
         wcnt++;
         if (!drop[idx] && wcnt > (idx % 3)) begin
            rd_valid = 1'b1;
            rd_data  = {mem_byte(idx), {7{~mem_byte(idx)}}};
         end
      end else begin
         wcnt = 0;
      end
   end

   // monitor: pops expected addresses, times the request windows and done
   bit          prev_req = 1'b0, prev_done = 1'b0;
   int          hi = 0, cur_idx = 0;
   logic [15:0] last_addr = '0;
   bit          exp_valid_at_done = 1'b1;
   always begin
      @(posedge clk);
      #2;
      if (!rst_n || !mon_en) begin
         prev_req = 1'b0;
         prev_done = 1'b0;
         hi = 0;
      end else begin
         if (rd_req && !prev_req) begin
            if (exp_addr_q.size() == 0) begin
               check(1'b0, "R1 read beyond the expected series", rd_addr, 0);
            end else begin
               logic [15:0] e;
               e = exp_addr_q.pop_front();
               check(rd_addr == e, "R2 read address", rd_addr, e);
            end
            cur_idx = int'(rd_addr >> 3);
            hi = 1;
         end else if (rd_req && prev_req) begin
            hi++;
            check(rd_addr == last_addr, "R6 address held while waiting", rd_addr, last_addr);
         end else if (!rd_req && prev_req && drop[cur_idx]) begin
            check(hi == TMO, "R8 request window before expiry", hi, TMO);
         end
         if (done && !prev_done) begin
            check(rd_valid == exp_valid_at_done, "R7 done on the final capture edge",
                  rd_valid, exp_valid_at_done);
         end
         last_addr = rd_addr;
         prev_req  = rd_req;
         prev_done = done;
      end
   end

   bit wd_hit = 1'b0;

   task automatic run_fetch(input logic [7:0] s, input int da, input int db);
      logic [255:0] snap;
      seed = s;
      for (int i = 0; i < NR; i++) drop[i] = (i == da) || (i == db);
      exp_valid_at_done = !drop[NR-1];
      exp_addr_q.delete();
      for (int w = 0; w < NW; w++) begin
         int d;
         d = -1;
         for (int k = 3; k >= 0; k--) if (drop[4*w+k]) d = k;
         exp_words[w] = {mem_byte(4*w), mem_byte(4*w+1), mem_byte(4*w+2), mem_byte(4*w+3)};
         if (d >= 0) exp_words[w] = DEFW;
         for (int k = 0; k < 4; k++)
            if (d < 0 || k <= d) exp_addr_q.push_back(16'((4*w + k) * 8));
      end

      mon_en = 1'b0;
      rst_n  = 1'b0;
      repeat (3) @(negedge clk);
      check(rd_req == 1'b0, "R9 request low in reset", rd_req, 0);
      check(busy == 1'b1 && done == 1'b0, "R9 busy/done in reset", {busy, done}, 2'b10);
      check(cfg_err == 1'b0, "R9 error clear in reset", cfg_err, 0);
      check(cfg_words == '0, "R9 words zero in reset", cfg_words[63:0], 0);
      mon_en = 1'b1;
      rst_n  = 1'b1;
      repeat (5) @(negedge clk);
      check(busy == 1'b1 && done == 1'b0, "R7 busy while fetching", {busy, done}, 2'b10);

      while (!done && cyc < WD_LIMIT) @(negedge clk);
      if (!done) begin
         wd_hit = 1'b1;
         check(1'b0, "R1 watchdog: done never rose", done, 1);
         return;
      end
      repeat (3) @(negedge clk);
      for (int w = 0; w < NW; w++)
         check(cfg_words[32*w +: 32] == exp_words[w], $sformatf("R3 R4 R5 word %0d", w),
               cfg_words[32*w +: 32], exp_words[w]);
      check(exp_addr_q.size() == 0, "R1 reads left unissued", exp_addr_q.size(), 0);
      check(cfg_err == (da >= 0 || db >= 0), "R8 error flag", cfg_err, (da >= 0 || db >= 0));
      snap = cfg_words;
      repeat (20) begin
         @(negedge clk);
         if (rd_req) break;
      end
      check(rd_req == 1'b0, "R1 no request after done", rd_req, 0);
      check(done == 1'b1 && busy == 1'b0, "R7 done held", {done, busy}, 2'b10);
      check(cfg_words == snap, "R7 words frozen after done", cfg_words[63:0], snap[63:0]);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      run_fetch(8'h00, -1, -1);               // all answered
      if (!wd_hit) run_fetch(8'h5A, 9, 31);   // R8: mid-word and final read withheld
      if (!wd_hit) run_fetch(8'hC3, 0, -1);   // R8: master word's first read withheld
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule